// File: doc/BRIEF.md
# Shadowed Base-Register Address Former

This block turns a base-register number and a 16-bit displacement into a full-width memory address without a carry-propagating add. For each architectural base register it keeps up to four shadow registers. Each shadow holds the already-translated address of one equal share of the displacement range. A lookup picks the shadow that covers the displacement and replaces that shadow's low bits with the displacement's low bits. No addition is done.

Each base register carries a shadowing mode: unshadowed, one shadow, two shadows or four shadows. Software writes the base register, which sets the mode and discards every shadow of that base. It then loads the shadows one at a time through a write port. A lookup that cannot be served this way raises a slow-path flag so that a full adder elsewhere can take over. This happens when the base is unshadowed, when the chosen shadow was not loaded, or when the chosen shadow's low bits are not zero, which means its share of the range is not mapped uniformly. The lookup is combinational. The mode, valid and shadow state it reads is registered.

Top module: `shadow_agen`

## Requirements
- R1: After reset every base is unshadowed and holds no valid shadow, so every request raises `slow_path`.
- R2: `base_mode` is encoded as 2'b00 unshadowed, 2'b01 one shadow, 2'b10 two shadows and 2'b11 four shadows. An unshadowed base raises `slow_path` on every request, even if its shadows were loaded.
- R3: In four-shadow mode, displacement bits 15:14 select shadow slot 0 to 3, and `fast_addr` is that shadow with bits 13:0 replaced by displacement bits 13:0.
- R4: In two-shadow mode, displacement bit 15 selects slot 0 or 1, and `fast_addr` is that shadow with bits 14:0 replaced by displacement bits 14:0.
- R5: In one-shadow mode, slot 0 is used, and `fast_addr` is that shadow with bits 15:0 replaced by the whole displacement.
- R6: If any of the bits the mode replaces is nonzero in the chosen shadow, the request raises `slow_path` and `fast_valid` stays low.
- R7: A request whose chosen slot has not been loaded since the last write of its base raises `slow_path`.
- R8: A write of a base register clears the valid state of all four of its shadows, effective from the next cycle. Other bases are unaffected.
- R9: A shadow write (`sh_base`, `sh_slot` 0 to 3, `sh_data`) is visible to lookups from the cycle after the write and not in the same cycle.
- R10: With `req_valid` high, exactly one of `fast_valid` and `slow_path` is high. With `req_valid` low, both are low. `fast_addr` is zero whenever `fast_valid` is low.
- R11: When a base write and a shadow write target the same base in one cycle, the base write wins and the shadow write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Base register write strobe |
| base_idx | input | IDX_W | Base register written |
| base_mode | input | 2 | Shadowing mode for the written base |
| sh_we | input | 1 | Shadow write strobe |
| sh_base | input | IDX_W | Base owning the shadow written |
| sh_slot | input | 2 | Shadow slot written |
| sh_data | input | ADDR_W | Pre-translated shadow address |
| req_valid | input | 1 | Address request present |
| req_base | input | IDX_W | Base register used by the request |
| req_disp | input | DISP_W | Displacement of the request |
| fast_valid | output | 1 | Merged address is valid |
| fast_addr | output | ADDR_W | Merged address, zero when not valid |
| slow_path | output | 1 | Request needs the full adder |

## Verification
In four-shadow mode, a displacement is sent into each quarter of the range. Every slot holds a different value, so picking the wrong slot shows up as a different address. In two-shadow mode, displacements just below and at the halfway point are used. The upper shadow has bit 15 set, which shows whether the merge width is 14, 15 or 16 bits. One shadow value whose bit 14 is set is tried in two-shadow mode, where it must fall back to the slow path, and then in four-shadow mode, where it must merge. This tells the low-bit check of each mode apart. Further patterns are an all-ones displacement in one-shadow mode, requests to unloaded slots, an unshadowed base that has loaded shadows, base rewrites and same-cycle write collisions. These show when state takes effect.

// File: rtl/shadow_agen_pkg.sv
package shadow_agen_pkg;
  localparam int SLOTS  = 4;
  localparam int SLOT_W = 2;

  typedef enum logic [1:0] {
    SHM_NONE = 2'b00,
    SHM_ONE  = 2'b01,
    SHM_TWO  = 2'b10,
    SHM_FOUR = 2'b11
  } shm_mode_e;
endpackage

// File: rtl/shadow_agen_file.sv
module shadow_agen_file
  import shadow_agen_pkg::*;
#(
  parameter int NUM_BASE = 8,
  parameter int ADDR_W   = 64,
  localparam int IDX_W   = $clog2(NUM_BASE)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          base_we,
  input  logic [IDX_W-1:0]              base_idx,
  input  shm_mode_e                     base_mode,
  input  logic                          sh_we,
  input  logic [IDX_W-1:0]              sh_base,
  input  logic [SLOT_W-1:0]             sh_slot,
  input  logic [ADDR_W-1:0]             sh_data,
  input  logic [IDX_W-1:0]              rd_base,
  output shm_mode_e                     rd_mode,
  output logic [SLOTS-1:0]              rd_valid,
  output logic [SLOTS-1:0][ADDR_W-1:0]  rd_data
);

  shm_mode_e                     mode_all  [NUM_BASE];
  logic [SLOTS-1:0]              valid_all [NUM_BASE];
  logic [SLOTS-1:0][ADDR_W-1:0]  data_all  [NUM_BASE];

  for (genvar b = 0; b < NUM_BASE; b++) begin : g_base
    localparam logic [IDX_W-1:0] B_ID = IDX_W'(b);

    shm_mode_e                    mode_r, mode_d;
    logic [SLOTS-1:0]             valid_r, valid_d;
    logic [SLOTS-1:0][ADDR_W-1:0] data_r;
    logic [SLOTS-1:0]             data_en;
    logic                         base_hit, sh_hit;

    // a base write to the same base takes precedence over a shadow load
    assign base_hit = base_we && (base_idx == B_ID);
    assign sh_hit   = sh_we && (sh_base == B_ID) && !base_hit;

    always_comb begin
      mode_d  = mode_r;
      valid_d = valid_r;
      data_en = '0;
      if (base_hit) begin
        mode_d  = base_mode;
        valid_d = '0;
      end else if (sh_hit) begin
        valid_d[sh_slot] = 1'b1;
        data_en[sh_slot] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_r  <= SHM_NONE;
        valid_r <= '0;
      end else begin
        mode_r  <= mode_d;
        valid_r <= valid_d;
      end
    end

    // shadow payload carries no reset: it is qualified by valid_r
    always_ff @(posedge clk) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (data_en[s]) data_r[s] <= sh_data;
      end
    end

    assign mode_all[b]  = mode_r;
    assign valid_all[b] = valid_r;
    assign data_all[b]  = data_r;
  end

  assign rd_mode  = mode_all[rd_base];
  assign rd_valid = valid_all[rd_base];
  assign rd_data  = data_all[rd_base];

endmodule

// File: rtl/shadow_agen_select.sv
module shadow_agen_select
  import shadow_agen_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 16
) (
  input  shm_mode_e                     mode,
  input  logic [SLOTS-1:0]              valid,
  input  logic [SLOTS-1:0][ADDR_W-1:0]  data,
  input  logic                          req_valid,
  input  logic [DISP_W-1:0]             disp,
  output logic                          fast_valid,
  output logic [ADDR_W-1:0]             fast_addr,
  output logic                          slow_path
);

  localparam logic [ADDR_W-1:0] MASK_ONE  = ADDR_W'({DISP_W{1'b1}});
  localparam logic [ADDR_W-1:0] MASK_TWO  = ADDR_W'({(DISP_W-1){1'b1}});
  localparam logic [ADDR_W-1:0] MASK_FOUR = ADDR_W'({(DISP_W-2){1'b1}});

  logic [SLOT_W-1:0] slot;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] sel;
  logic [ADDR_W-1:0] disp_ext;
  logic              usable;

  always_comb begin
    slot = '0;
    mask = '0;
    unique case (mode)
      SHM_ONE:  begin slot = '0;                           mask = MASK_ONE;  end
      SHM_TWO:  begin slot = {1'b0, disp[DISP_W-1]};       mask = MASK_TWO;  end
      SHM_FOUR: begin slot = disp[DISP_W-1 -: SLOT_W];     mask = MASK_FOUR; end
      default:  begin slot = '0;                           mask = '0;        end
    endcase
  end

  assign sel      = data[slot];
  assign disp_ext = ADDR_W'(disp);
  assign usable   = (mode != SHM_NONE) && valid[slot] && ((sel & mask) == '0);

  assign fast_valid = req_valid && usable;
  assign slow_path  = req_valid && !usable;
  assign fast_addr  = fast_valid ? ((sel & ~mask) | (disp_ext & mask)) : '0;

endmodule

// File: rtl/shadow_agen.sv
module shadow_agen
  import shadow_agen_pkg::*;
#(
  parameter int NUM_BASE = 8,
  parameter int ADDR_W   = 64,
  parameter int DISP_W   = 16,
  localparam int IDX_W   = $clog2(NUM_BASE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [1:0]        base_mode,
  input  logic              sh_we,
  input  logic [IDX_W-1:0]  sh_base,
  input  logic [1:0]        sh_slot,
  input  logic [ADDR_W-1:0] sh_data,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_base,
  input  logic [DISP_W-1:0] req_disp,
  output logic              fast_valid,
  output logic [ADDR_W-1:0] fast_addr,
  output logic              slow_path
);

  shm_mode_e                     rd_mode;
  logic [SLOTS-1:0]              rd_valid;
  logic [SLOTS-1:0][ADDR_W-1:0]  rd_data;

  shadow_agen_file #(
    .NUM_BASE (NUM_BASE),
    .ADDR_W   (ADDR_W)
  ) u_file (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_we   (base_we),
    .base_idx  (base_idx),
    .base_mode (shm_mode_e'(base_mode)),
    .sh_we     (sh_we),
    .sh_base   (sh_base),
    .sh_slot   (sh_slot),
    .sh_data   (sh_data),
    .rd_base   (req_base),
    .rd_mode   (rd_mode),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  shadow_agen_select #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W)
  ) u_select (
    .mode       (rd_mode),
    .valid      (rd_valid),
    .data       (rd_data),
    .req_valid  (req_valid),
    .disp       (req_disp),
    .fast_valid (fast_valid),
    .fast_addr  (fast_addr),
    .slow_path  (slow_path)
  );

endmodule

// File: rtl/shadow_agen_checker.sv
module shadow_agen_checker #(
  parameter int NUM_BASE = 8,
  parameter int ADDR_W   = 64,
  parameter int DISP_W   = 16,
  localparam int IDX_W   = $clog2(NUM_BASE)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              base_we,
  input logic [IDX_W-1:0]  base_idx,
  input logic              req_valid,
  input logic [IDX_W-1:0]  req_base,
  input logic [DISP_W-1:0] req_disp,
  input logic              fast_valid,
  input logic [ADDR_W-1:0] fast_addr,
  input logic              slow_path
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (fast_valid != slow_path));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!fast_valid && !slow_path));

  assert_addr_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_valid |-> (fast_addr == '0));

  // every shadowed mode merges at least the low DISP_W-2 displacement bits
  assert_low_merge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fast_valid |-> (fast_addr[DISP_W-3:0] == req_disp[DISP_W-3:0]));

  assert_base_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(base_we) && req_valid && (req_base == $past(base_idx)))
      |-> !fast_valid);

endmodule

bind shadow_agen shadow_agen_checker #(
  .NUM_BASE (NUM_BASE),
  .ADDR_W   (ADDR_W),
  .DISP_W   (DISP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .base_we    (base_we),
  .base_idx   (base_idx),
  .req_valid  (req_valid),
  .req_base   (req_base),
  .req_disp   (req_disp),
  .fast_valid (fast_valid),
  .fast_addr  (fast_addr),
  .slow_path  (slow_path)
);

// File: tb/shadow_agen_bench.sv
module shadow_agen_bench;
  localparam int NB = 8;
  localparam int AW = 64;
  localparam int DW = 16;
  localparam int IW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          base_we;
  logic [IW-1:0] base_idx;
  logic [1:0]    base_mode;
  logic          sh_we;
  logic [IW-1:0] sh_base;
  logic [1:0]    sh_slot;
  logic [AW-1:0] sh_data;
  logic          req_valid;
  logic [IW-1:0] req_base;
  logic [DW-1:0] req_disp;
  logic          fast_valid;
  logic [AW-1:0] fast_addr;
  logic          slow_path;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  shadow_agen #(.NUM_BASE(NB), .ADDR_W(AW), .DISP_W(DW)) u_shadow_agen (
    .clk(clk), .rst_n(rst_n),
    .base_we(base_we), .base_idx(base_idx), .base_mode(base_mode),
    .sh_we(sh_we), .sh_base(sh_base), .sh_slot(sh_slot), .sh_data(sh_data),
    .req_valid(req_valid), .req_base(req_base), .req_disp(req_disp),
    .fast_valid(fast_valid), .fast_addr(fast_addr), .slow_path(slow_path)
  );

  task automatic compare(input string tag, input logic exp_fast, input logic exp_slow,
                         input logic [AW-1:0] exp_addr);
    n_chk++;
    if (fast_valid !== exp_fast || slow_path !== exp_slow || fast_addr !== exp_addr) begin
      n_fail++;
      $display("FAIL %s: fast=%b slow=%b addr=%h expected fast=%b slow=%b addr=%h",
               tag, fast_valid, slow_path, fast_addr, exp_fast, exp_slow, exp_addr);
    end
  endtask

  // request is applied mid-cycle; outputs are sampled 1 ns later, before the edge
  task automatic lookup(input string tag, input int b, input logic [DW-1:0] d,
                        input logic exp_fast, input logic [AW-1:0] exp_addr);
    req_valid = 1'b1;
    req_base  = IW'(b);
    req_disp  = d;
    #1;
    compare(tag, exp_fast, !exp_fast, exp_fast ? exp_addr : '0);
    req_valid = 1'b0;
  endtask

  task automatic wr_base(input int b, input logic [1:0] m);
    @(negedge clk);
    base_we = 1'b1; base_idx = IW'(b); base_mode = m;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  task automatic wr_shadow(input int b, input int s, input logic [AW-1:0] v);
    @(negedge clk);
    sh_we = 1'b1; sh_base = IW'(b); sh_slot = 2'(s); sh_data = v;
    @(negedge clk);
    sh_we = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    lookup("R1 reset base0", 0, 16'h0000, 1'b0, '0);
    lookup("R1 reset base7", 7, 16'hFFFF, 1'b0, '0);
  endtask

  task automatic t_quad;
    wr_base(1, 2'b11);
    for (int s = 0; s < 4; s++) wr_shadow(1, s, 64'h0000_00A0_0000_0000 | (64'(s + 1) << 20));
    @(negedge clk);
    lookup("R3 quad slot0", 1, 16'h0123, 1'b1, 64'h0000_00A0_0010_0123);
    lookup("R3 quad slot1", 1, 16'h5ABC, 1'b1, 64'h0000_00A0_0020_1ABC);
    lookup("R3 quad slot2", 1, 16'h8001, 1'b1, 64'h0000_00A0_0030_0001);
    lookup("R3 quad slot3", 1, 16'hFFFF, 1'b1, 64'h0000_00A0_0040_3FFF);
  endtask

  task automatic t_visibility;
    wr_base(2, 2'b11);
    @(negedge clk);
    sh_we = 1'b1; sh_base = 3'd2; sh_slot = 2'd1; sh_data = 64'h1234_5678_9ABC_0000;
    lookup("R9 same cycle", 2, 16'h4005, 1'b0, '0);
    @(negedge clk);
    sh_we = 1'b0;
    lookup("R9 next cycle", 2, 16'h4005, 1'b1, 64'h1234_5678_9ABC_0005);
  endtask

  task automatic t_pair;
    wr_base(3, 2'b10);
    wr_shadow(3, 0, 64'h0000_1111_2222_0000);
    wr_shadow(3, 1, 64'h0000_3333_4444_8000);
    @(negedge clk);
    lookup("R4 pair low half", 3, 16'h7FFF, 1'b1, 64'h0000_1111_2222_7FFF);
    lookup("R4 pair high half", 3, 16'h8005, 1'b1, 64'h0000_3333_4444_8005);
  endtask

  task automatic t_single;
    wr_base(4, 2'b01);
    wr_shadow(4, 0, 64'hDEAD_BEEF_0001_0000);
    @(negedge clk);
    lookup("R5 single ones", 4, 16'hFFFF, 1'b1, 64'hDEAD_BEEF_0001_FFFF);
    lookup("R5 single zero", 4, 16'h0000, 1'b1, 64'hDEAD_BEEF_0001_0000);
  endtask

  task automatic t_lowbits;
    wr_base(5, 2'b11);
    wr_shadow(5, 2, 64'h0000_0000_7777_8001);
    @(negedge clk);
    lookup("R6 quad low bit set", 5, 16'h8000, 1'b0, '0);
    lookup("R7 unloaded slot", 5, 16'h0000, 1'b0, '0);
    wr_base(6, 2'b10);
    wr_shadow(6, 0, 64'h0000_0055_0000_4000);
    @(negedge clk);
    lookup("R6 pair bit14 set", 6, 16'h0010, 1'b0, '0);
    wr_base(6, 2'b11);
    wr_shadow(6, 1, 64'h0000_0055_0000_4000);
    @(negedge clk);
    lookup("R6 quad bit14 ok", 6, 16'h4010, 1'b1, 64'h0000_0055_0000_4010);
  endtask

  task automatic t_unshadowed;
    wr_base(7, 2'b00);
    wr_shadow(7, 0, 64'h0000_0000_0001_0000);
    @(negedge clk);
    lookup("R2 unshadowed", 7, 16'h0001, 1'b0, '0);
  endtask

  task automatic t_clear;
    wr_base(1, 2'b11);
    @(negedge clk);
    lookup("R8 cleared slot0", 1, 16'h0123, 1'b0, '0);
    lookup("R8 cleared slot3", 1, 16'hFFFF, 1'b0, '0);
    lookup("R8 other base kept", 3, 16'h7FFF, 1'b1, 64'h0000_1111_2222_7FFF);
  endtask

  task automatic t_collision;
    @(negedge clk);
    base_we = 1'b1; base_idx = 3'd4; base_mode = 2'b01;
    sh_we = 1'b1; sh_base = 3'd4; sh_slot = 2'd0; sh_data = 64'h0000_0000_0002_0000;
    @(negedge clk);
    base_we = 1'b0; sh_we = 1'b0;
    lookup("R11 shadow dropped", 4, 16'h0001, 1'b0, '0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    req_valid = 1'b0; req_base = 3'd3; req_disp = 16'h7FFF;
    #1;
    compare("R10 idle", 1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    base_we = 1'b0; base_idx = '0; base_mode = '0;
    sh_we = 1'b0; sh_base = '0; sh_slot = '0; sh_data = '0;
    req_valid = 1'b0; req_base = '0; req_disp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_quad();
    t_visibility();
    t_pair();
    t_single();
    t_lowbits();
    t_unshadowed();
    t_clear();
    t_collision();
    t_idle();
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule